// File: doc/BRIEF.md
# Coarse-Fine Regulator Switch Controller

This block closes the digital loop of a low-dropout regulator. A clocked comparator reports whether the regulated output sits above the reference (`cmp_hi`). A strobe (`cmp_done`) marks that decision as settled. Two window flags report a large excursion above or below the reference. From these the block drives two thermometer-coded banks of power-switch enables. In the coarse bank each enable bit drives a group of eight switches. In the fine bank each enable bit drives a single switch.

During a large transient the controller runs in coarse mode. It moves the coarse bank one group per decision, and it moves on every rising and every falling edge of the fast clock. Once the output crosses the reference, which shows up as a reversal of the decision, control passes to fine mode. In fine mode the fine bank moves one switch per decision, but only on the edges of an internally divided slow clock. Both edges of that slow clock count. The block also exports the slow clock and a select that tells the comparator clocking logic whether to use the fast or the slow clock.

If the fine bank pins against one of its limits for several decisions in a row, the controller goes back to coarse mode. It also goes back at once whenever a window flag fires.

Top module: `dldo_ctrl`

## Requirements
- R1: While reset is asserted the block is in coarse mode with the coarse direction set to "add": `cmp_fast_sel` is 1, the lowest NC/2 bits of `en_coarse` are 1, the lowest NF/2 bits of `en_fine` are 1, and `slow_clk` is 0.
- R2: The state advances on both the rising and the falling edge of `clk`. Outputs reflect the decision taken at an edge right after that same edge.
- R3: In coarse mode, an edge with `cmp_done`=1 and `cmp_hi` equal to the coarse direction moves the coarse count by one group. `cmp_hi`=1 removes a group and `cmp_hi`=0 adds one. The count saturates at 0 and at NC.
- R4: In coarse mode, an edge with `cmp_done`=1 and `cmp_hi` different from the coarse direction switches to fine mode and leaves both banks unchanged.
- R5: `slow_clk` toggles on every DIV-th edge of `clk`, counted from reset. In fine mode the fine count moves by one only on those toggling edges and only when `cmp_done`=1. It moves down if `cmp_hi`=1 and up if `cmp_hi`=0, and it saturates at 0 and at NF.
- R6: An edge with `cmp_done`=0 changes neither bank and causes no mode change from the comparator decision.
- R7: In fine mode, `over_flag` or `under_flag` high at any edge enters coarse mode with no shift. The coarse direction becomes "remove" if `over_flag` is set, since it has priority, and "add" otherwise.
- R8: In fine mode, a fine update that cannot move because the fine count sits at the limit in the decided direction is "blocked". The fourth blocked update in a row enters coarse mode, with the direction taken from that decision. A fine update that moves clears the run.
- R9: `cmp_fast_sel` is 1 in coarse mode and 0 in fine mode, and it changes on the same edge as the mode.
- R10: In coarse mode `over_flag` and `under_flag` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, both edges active |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_hi | input | 1 | Comparator decision: output above reference |
| cmp_done | input | 1 | Comparator decision complete |
| over_flag | input | 1 | Upper window comparator: overshoot |
| under_flag | input | 1 | Lower window comparator: undershoot |
| en_coarse | output | NC | Thermometer enables, one per group of eight switches |
| en_fine | output | NF | Thermometer enables, one per single switch |
| slow_clk | output | 1 | Divided clock that paces fine updates |
| cmp_fast_sel | output | 1 | 1: comparator on fast clock, 0: on slow clock |

## Verification
Every result is due right after the `clk` edge that consumes the inputs, on both rising and falling edges. The bench drives inputs 5 ns after an edge and pushes the expected outcome for the next edge into a queue. The monitor pops and compares that entry 3 ns after the next edge, so each output is checked on the edge it belongs to. Fine-bank changes are due only on edges where `slow_clk` toggles, once every DIV edges. The bench model counts these edges from reset, so a change that lands one edge early or late shows up as a miscompare.

// File: rtl/dldo_ctrl.sv
module dldo_ctrl #(
  parameter int NC      = 8,
  parameter int NF      = 16,
  parameter int DIV     = 4,
  parameter int RUN_LEN = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmp_hi,
  input  logic          cmp_done,
  input  logic          over_flag,
  input  logic          under_flag,
  output logic [NC-1:0] en_coarse,
  output logic [NF-1:0] en_fine,
  output logic          slow_clk,
  output logic          cmp_fast_sel
);
  localparam int CW = $clog2(NC + 1);
  localparam int FW = $clog2(NF + 1);
  localparam int RW = $clog2(RUN_LEN);
  localparam int DW = $clog2(DIV);
  localparam logic [CW-1:0] C_MAX = CW'(NC);
  localparam logic [FW-1:0] F_MAX = FW'(NF);
  localparam logic [RW-1:0] R_LAST = RW'(RUN_LEN - 1);
  localparam logic [DW-1:0] D_LAST = DW'(DIV - 1);

  typedef struct packed {
    logic          coarse;
    logic          dir;
    logic [CW-1:0] c;
    logic [FW-1:0] f;
    logic [RW-1:0] run;
    logic [DW-1:0] div;
    logic          slow;
  } st_t;

  localparam st_t INIT = '{coarse: 1'b1, dir: 1'b0, c: CW'(NC / 2), f: FW'(NF / 2),
                           run: '0, div: '0, slow: 1'b0};

  function automatic st_t step(input st_t s, input logic hi, input logic done,
                               input logic ovs, input logic uds);
    st_t n;
    logic se;
    logic blocked;
    n  = s;
    se = (s.div == D_LAST);
    n.div = se ? '0 : s.div + DW'(1);
    if (se) n.slow = ~s.slow;
    blocked = hi ? (s.f == '0) : (s.f == F_MAX);
    if (s.coarse) begin
      if (done) begin
        if (hi != s.dir) begin
          n.coarse = 1'b0;
          n.run    = '0;
        end else if (hi) begin
          if (s.c != '0) n.c = s.c - CW'(1);
        end else if (s.c != C_MAX) begin
          n.c = s.c + CW'(1);
        end
      end
    end else if (ovs || uds) begin
      n.coarse = 1'b1;
      n.dir    = ovs;
      n.run    = '0;
    end else if (se && done) begin
      if (blocked) begin
        if (s.run == R_LAST) begin
          n.coarse = 1'b1;
          n.dir    = hi;
          n.run    = '0;
        end else begin
          n.run = s.run + RW'(1);
        end
      end else begin
        n.f   = hi ? s.f - FW'(1) : s.f + FW'(1);
        n.run = '0;
      end
    end
    return n;
  endfunction

  st_t s_p, s_n, nx_p, nx_n, cur;

  always_comb begin
    nx_p = step(s_n, cmp_hi, cmp_done, over_flag, under_flag);
    nx_n = step(s_p, cmp_hi, cmp_done, over_flag, under_flag);
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) s_p <= INIT;
    else        s_p <= nx_p;

  always_ff @(negedge clk or negedge rst_n)
    if (!rst_n) s_n <= INIT;
    else        s_n <= nx_n;

  assign cur = clk ? s_p : s_n;

  always_comb begin
    for (int i = 0; i < NC; i++) en_coarse[i] = (cur.c > CW'(i));
    for (int i = 0; i < NF; i++) en_fine[i]   = (cur.f > FW'(i));
  end

  assign slow_clk     = cur.slow;
  assign cmp_fast_sel = cur.coarse;

  // Between two rising edges the coarse count moves by at most two groups (R3)
  p_coarse_stride_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(s_p.c) - int'($past(s_p.c)) <= 2) && (int'($past(s_p.c)) - int'(s_p.c) <= 2));

  // Fine count moves by at most one per rising-edge pair, as slow edges are DIV apart (R5)
  p_fine_stride_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (s_p.f == $past(s_p.f)) || (s_p.f == $past(s_p.f) + FW'(1)) || (s_p.f + FW'(1) == $past(s_p.f)));

  // Without a completed decision and without flags nothing but the divider moves (R6)
  p_no_done_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmp_done && !over_flag && !under_flag) |=>
      (s_p.c == $past(s_n.c) && s_p.f == $past(s_n.f) && s_p.coarse == $past(s_n.coarse)));

  // Fine mode off a slow edge and without flags keeps the fine count and mode (R5)
  p_slow_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!s_n.coarse && s_n.div != D_LAST && !over_flag && !under_flag) |=>
      (s_p.f == $past(s_n.f) && !s_p.coarse));

  // In coarse mode the window flags cannot alter the coarse count without a decision (R10)
  p_flag_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (s_n.coarse && !cmp_done) |=> (s_p.coarse && s_p.c == $past(s_n.c)));
endmodule

// File: tb/tb_dldo_ctrl.sv
module tb_dldo_ctrl;
  localparam int NC = 8, NF = 16, DIV = 4, RUN = 4, GRP = 8, TH = 12;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmp_hi = 1'b0, cmp_done = 1'b0, over_flag = 1'b0, under_flag = 1'b0;
  logic [NC-1:0] en_coarse;
  logic [NF-1:0] en_fine;
  logic slow_clk, cmp_fast_sel;

  dldo_ctrl #(.NC(NC), .NF(NF), .DIV(DIV), .RUN_LEN(RUN)) dut (
    .clk(clk), .rst_n(rst_n), .cmp_hi(cmp_hi), .cmp_done(cmp_done),
    .over_flag(over_flag), .under_flag(under_flag), .en_coarse(en_coarse),
    .en_fine(en_fine), .slow_clk(slow_clk), .cmp_fast_sel(cmp_fast_sel));

  always #10 clk = ~clk;

  int n_vec = 0, n_bad = 0, load = 40;
  bit finished = 0;
  int exp_q[$];
  string tag_q[$];

  int m_c = NC / 2, m_f = NF / 2, m_run = 0, m_div = 0;
  bit m_coarse = 1, m_dir = 0, m_slow = 0;

  task automatic model_step(bit hi, bit done, bit ov, bit un);
    bit se;
    se = (m_div == DIV - 1);
    m_div = se ? 0 : m_div + 1;
    if (se) m_slow = !m_slow;
    if (m_coarse) begin
      if (done) begin
        if (hi != m_dir) begin m_coarse = 0; m_run = 0; end
        else if (hi) begin if (m_c > 0) m_c--; end
        else if (m_c < NC) m_c++;
      end
    end else if (ov || un) begin
      m_coarse = 1; m_dir = ov; m_run = 0;
    end else if (se && done) begin
      if (hi ? (m_f == 0) : (m_f == NF)) begin
        if (m_run == RUN - 1) begin m_coarse = 1; m_dir = hi; m_run = 0; end
        else m_run++;
      end else begin
        m_f = hi ? m_f - 1 : m_f + 1;
        m_run = 0;
      end
    end
  endtask

  function automatic int pack_exp();
    return m_c | (m_f << 8) | (int'(m_coarse) << 16) | (int'(m_slow) << 17);
  endfunction

  task automatic compare(string tag, int e);
    logic [NC-1:0] ec;
    logic [NF-1:0] ef;
    bit eco, esl;
    ec  = NC'((1 << (e & 255)) - 1);
    ef  = NF'((1 << ((e >> 8) & 255)) - 1);
    eco = e[16];
    esl = e[17];
    n_vec++;
    if (en_coarse !== ec || en_fine !== ef || cmp_fast_sel !== eco || slow_clk !== esl) begin
      n_bad++;
      $display("FAIL %s t=%0t: actual c=%b f=%b sel=%b slow=%b expected c=%b f=%b sel=%b slow=%b",
               tag, $time, en_coarse, en_fine, cmp_fast_sel, slow_clk, ec, ef, eco, esl);
    end
  endtask

  task automatic drive_tick(string tag, bit forced);
    int err;
    bit hi, dn, ov, un;
    if (forced) begin
      dn = 0; hi = 1'($urandom); ov = 1'($urandom); un = 1'($urandom);
    end else begin
      err = m_c * GRP + m_f - load;
      hi = err > 0; ov = err > TH; un = err < -TH;
      dn = ($urandom % 6) != 0;
    end
    cmp_hi = hi; cmp_done = dn; over_flag = ov; under_flag = un;
    model_step(hi, dn, ov, un);
    exp_q.push_back(pack_exp());
    tag_q.push_back(tag);
  endtask

  task automatic phase(string tag, bit forced, int ld, int n);
    load = ld;
    for (int i = 0; i < n; i++) begin
      drive_tick(tag, forced);
      @(clk);
      #5;
    end
  endtask

  initial begin
    wait (rst_n);
    forever begin
      @(clk);
      #3;
      if (exp_q.size() > 0) compare(tag_q.pop_front(), exp_q.pop_front());
    end
  end

  initial begin
    #53;
    rst_n = 1'b1;
    compare("R1 reset state", pack_exp());
    #2;
    phase("R2 R5 R9 steady", 0, 40, 300);
    phase("R3 R4 R7 R9 undershoot step", 0, 70, 400);
    phase("R3 R4 R7 overshoot step", 0, 10, 400);
    phase("R6 R7 R10 incomplete decisions", 1, 10, 60);
    phase("R8 R3 upper saturation", 0, 200, 300);
    phase("R8 R3 lower saturation", 0, -20, 300);
    phase("R2 R4 R5 recovery", 0, 35, 400);
    repeat (4) @(clk);
    #4;
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog (R1..all requirements): actual=still running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule